// File: doc/BRIEF.md
# Integrating Loss-of-Frame Timer

This block turns a Severely Errored Frame (SEF) indication into a Loss of Frame (LOF) alarm. It samples the SEF level once per frame. A frame tick input gives one single-cycle pulse per 125 us frame. Time is measured only in frame ticks, so the 3 ms integration window is the same at every line rate, and the tick spacing in clock cycles does not matter. With the default setting, 3 ms is 24 frames.

An out-of-frame accumulator counts frames with SEF high. It does not restart when SEF drops for a short time. It keeps its value through in-frame gaps. This means an intermittent error pattern, such as about 1 ms of SEF in every few ms, still adds up to an LOF declaration. A second counter measures the current run of consecutive in-frame frames. When that run reaches the window length, the accumulator is cleared and any declared LOF is cancelled.

Top module: `lof_integrator`

## Requirements
- R1: During and after reset both counts are zero and `lof_out` is low.
- R2: The state changes only on a cycle with `frame_tick` high. SEF held high between ticks has no effect.
- R3: Each tick with `sef_in` high adds one to the out-of-frame count. The tick that brings the count to `LOF_FRAMES` (default 24) sets `lof_out` from the next clock edge.
- R4: Ticks with `sef_in` low hold the out-of-frame count while the in-frame run is shorter than `LOF_FRAMES`. An intermittent pattern therefore raises LOF after `LOF_FRAMES` accumulated SEF frames.
- R5: The tick that makes the in-frame run reach `LOF_FRAMES` consecutive frames clears the out-of-frame count to zero.
- R6: That same tick clears `lof_out`, if it is set, from the next clock edge.
- R7: Any tick with `sef_in` high restarts the in-frame run from zero.
- R8: Both counts saturate at `LOF_FRAMES`. `lof_out` stays high while SEF frames continue past the threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_tick | input | 1 | One-cycle pulse per frame; `sef_in` is sampled here |
| sef_in | input | 1 | Severely errored frame level |
| lof_out | output | 1 | Loss of frame alarm |

## Verification
The bench sweeps periodic SEF patterns across several on-lengths and several off-lengths. The off-lengths straddle the 23/24 boundary. This separates a design that restarts the accumulator on every gap from one that never clears it: the first would never raise LOF, and the second would raise LOF too early after a long clean gap. Directed runs check the points where a timer that is off by one would be visible:
- an LOF declared on the 23rd or 25th frame;
- an LOF cleared one frame early;
- a single SEF frame inside a clean run that fails to restart the in-frame count, which would cancel LOF too soon.

SEF is also held high between ticks, and the tick spacing is varied, so that a design counting clock cycles instead of frames would show up.

// File: rtl/lof_timer_pkg.sv
package lof_timer_pkg;
  localparam int unsigned LOF_FRAMES_DEFAULT = 24;

  typedef enum logic {
    ST_IN_FRAME = 1'b0,
    ST_LOF      = 1'b1
  } lof_state_e;
endpackage

// File: rtl/lof_rst_sync.sv
module lof_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lof_sat_counter.sv
module lof_sat_counter #(
  parameter int unsigned LIMIT = 24,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic          inc_i,
  input  logic          clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          reach_o
);
  localparam logic [CW-1:0] LIM    = CW'(LIMIT);
  localparam logic [CW-1:0] LIM_M1 = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en_i) begin
      if (clr_i)                       cnt_d = '0;
      else if (inc_i && cnt_q != LIM)  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign reach_o = en_i & inc_i & ~clr_i & (cnt_q == LIM_M1);
  assign cnt_o   = cnt_q;

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIM);
  a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));
endmodule

// File: rtl/lof_alarm_ctrl.sv
module lof_alarm_ctrl
  import lof_timer_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic lof_o
);
  lof_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IN_FRAME: if (set_i) st_d = ST_LOF;
      ST_LOF:      if (clr_i && !set_i) st_d = ST_IN_FRAME;
      default:     st_d = ST_IN_FRAME;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IN_FRAME;
    else        st_q <= st_d;
  end

  assign lof_o = (st_q == ST_LOF);

  a_r3_declare: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> lof_o);
  a_r6_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !lof_o);
endmodule

// File: rtl/lof_integrator.sv
module lof_integrator #(
  parameter int unsigned LOF_FRAMES = lof_timer_pkg::LOF_FRAMES_DEFAULT,
  localparam int unsigned CW        = $clog2(LOF_FRAMES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_tick,
  input  logic sef_in,
  output logic lof_out
);
  logic          rst_n_int;
  logic [CW-1:0] oof_cnt, run_cnt;
  logic          oof_reach, run_reach;

  lof_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  // Accumulated out-of-frame frames; cleared only by a full clean run.
  lof_sat_counter #(.LIMIT(LOF_FRAMES)) u_oof_cnt (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en_i    (frame_tick),
    .inc_i   (sef_in),
    .clr_i   (run_reach),
    .cnt_o   (oof_cnt),
    .reach_o (oof_reach)
  );

  // Consecutive in-frame frames; any SEF frame restarts it.
  lof_sat_counter #(.LIMIT(LOF_FRAMES)) u_run_cnt (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en_i    (frame_tick),
    .inc_i   (~sef_in),
    .clr_i   (sef_in),
    .cnt_o   (run_cnt),
    .reach_o (run_reach)
  );

  lof_alarm_ctrl u_alarm (
    .clk   (clk),
    .rst_n (rst_n_int),
    .set_i (oof_reach),
    .clr_i (run_reach),
    .lof_o (lof_out)
  );

  a_r4_hold_in_gap: assert property (@(posedge clk) disable iff (!rst_n_int)
    (frame_tick && !sef_in && run_cnt != CW'(LOF_FRAMES - 1)) |=> $stable(oof_cnt));
  a_r5_clear_after_run: assert property (@(posedge clk) disable iff (!rst_n_int)
    (frame_tick && !sef_in && run_cnt == CW'(LOF_FRAMES - 1)) |=> (oof_cnt == '0));
  a_r7_run_restart: assert property (@(posedge clk) disable iff (!rst_n_int)
    (frame_tick && sef_in) |=> (run_cnt == '0));
  a_r2_lof_quiet: assert property (@(posedge clk) disable iff (!rst_n_int)
    !frame_tick |=> $stable(lof_out));
  a_r3_rise_on_sef: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(lof_out) |-> $past(frame_tick && sef_in));
  a_r6_fall_on_clean: assert property (@(posedge clk) disable iff (!rst_n_int)
    $fell(lof_out) |-> $past(frame_tick && !sef_in));
  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n_int |-> (!lof_out && oof_cnt == '0 && run_cnt == '0));
endmodule

// File: tb/lof_integrator_tb.sv
module lof_integrator_tb;
  localparam int N = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_tick;
  logic sef_in;
  logic lof_out;

  int n_chk = 0;
  int n_bad = 0;
  int m_oof, m_run;
  bit m_lof;
  int gap = 1;

  always #10 clk = ~clk;

  lof_integrator #(.LOF_FRAMES(N)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (frame_tick),
    .sef_in     (sef_in),
    .lof_out    (lof_out)
  );

  task automatic check(input string req, input bit act, input bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: lof_out=%0b expected %0b (oof=%0d run=%0d)", req, act, exp, m_oof, m_run);
    end
  endtask

  // Arithmetic model of the requirements, one step per frame.
  task automatic model_step(input bit s);
    if (s) begin
      m_run = 0;
      if (m_oof < N) begin
        m_oof++;
        if (m_oof == N) m_lof = 1'b1;   // R3
      end
    end else if (m_run < N) begin
      m_run++;
      if (m_run == N) begin             // R5, R6
        m_oof = 0;
        m_lof = 1'b0;
      end
    end
  endtask

  task automatic do_tick(input bit s, input string req);
    @(negedge clk);
    sef_in = s;
    frame_tick = 1'b1;
    @(negedge clk);
    frame_tick = 1'b0;
    model_step(s);
    check(req, lof_out, m_lof);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      sef_in = ~s;                      // R2: level between ticks is ignored
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    frame_tick = 1'b0;
    sef_in = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", lof_out, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_oof = 0; m_run = 0; m_lof = 1'b0;
    check("R1", lof_out, 1'b0);
  endtask

  initial begin
    #3_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_tick = 1'b0; sef_in = 1'b0;
    do_reset();

    // R2: SEF high for many cycles with no tick
    @(negedge clk); sef_in = 1'b1;
    repeat (200) @(negedge clk);
    check("R2", lof_out, 1'b0);

    // R3: declaration on the 24th SEF frame, R8 persistence, R6 cancel
    for (int i = 0; i < N; i++) do_tick(1'b1, "R3");
    check("R3", lof_out, 1'b1);
    for (int i = 0; i < 20; i++) do_tick(1'b1, "R8");
    for (int i = 0; i < N - 1; i++) do_tick(1'b0, "R6");
    check("R6", lof_out, 1'b1);
    do_tick(1'b0, "R6");
    check("R6", lof_out, 1'b0);

    // R4: 8 on / 16 off, three times
    do_reset();
    gap = 3;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < 8; i++)  do_tick(1'b1, "R4");
      for (int i = 0; i < 16; i++) do_tick(1'b0, "R4");
    end
    check("R4", lof_out, 1'b1);

    // R5: 23 SEF, 24 clean, then 23 SEF stays clear, 24th sets
    do_reset();
    gap = 1;
    for (int i = 0; i < N - 1; i++) do_tick(1'b1, "R5");
    for (int i = 0; i < N; i++)     do_tick(1'b0, "R5");
    for (int i = 0; i < N - 1; i++) do_tick(1'b1, "R5");
    check("R5", lof_out, 1'b0);
    do_tick(1'b1, "R5");
    check("R5", lof_out, 1'b1);

    // R7: a single SEF frame restarts the clean run
    do_reset();
    for (int i = 0; i < N; i++)     do_tick(1'b1, "R7");
    for (int i = 0; i < N - 1; i++) do_tick(1'b0, "R7");
    do_tick(1'b1, "R7");
    for (int i = 0; i < N - 1; i++) do_tick(1'b0, "R7");
    check("R7", lof_out, 1'b1);
    do_tick(1'b0, "R7");
    check("R7", lof_out, 1'b0);

    // Sweep of periodic patterns around the clean-run boundary
    for (int a = 1; a <= 4; a++) begin
      for (int b = 20; b <= 26; b++) begin
        do_reset();
        gap = (a + b) % 3;
        for (int t = 0; t < 60; t++) begin
          if ((t % (a + b)) < a) do_tick(1'b1, (b < N) ? "R4" : "R5");
          else                   do_tick(1'b0, (b < N) ? "R4" : "R5");
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule